// File: doc/BRIEF.md
# LCD Scanline Timing and Status Generator

This block counts clock cycles to build the line and frame timing of a 240-pixel-wide LCD. Each line opens with an active period in which a renderer draws pixels. A horizontal-blank period follows. A frame holds 228 lines. Lines 0 to 159 are shown on the panel and lines 160 to 227 form the vertical blank.

The block keeps the current line number and three status levels: horizontal blank, vertical blank and line match. It also emits single-cycle pulses at the timing edges:

- an interrupt request for each of the three events, each gated by its own enable input;
- a DMA trigger at the start of each horizontal blank and one at the start of the vertical blank;
- a draw request at the end of each visible active period.

Software places a line number on the compare input. The block tests it against each new line number as the counter advances. All pins are plain control and status signals; nothing here carries a data stream, so there is no handshake. The cycle counts are parameters: by default an active period lasts 960 cycles and a blank period lasts 272.

Top module: `lcd_line_timer`

## Requirements
- R1: After reset the line is 0, every flag and pulse output is low, and the cycle count starts at the first cycle of the active period of line 0.
- R2: The line output steps by one after each full line of ACTIVE_CYC+BLANK_CYC cycles (960+272 by default). It counts 0 to 227 and returns to 0 after 227.
- R3: The horizontal-blank flag is high exactly for the last BLANK_CYC cycles of every line, vertical-blank lines included.
- R4: In the first cycle of each horizontal blank, on every line, the H-blank DMA trigger pulses. The H-blank interrupt pulses in that same cycle only if its enable is high.
- R5: The draw pulse appears in the first horizontal-blank cycle of lines 0 to 159 only.
- R6: In the first cycle of a new line, the match flag takes the value (new line == compare input) and holds it for the whole line. The match interrupt pulses in that cycle if they are equal and the match enable is high. A change of the compare input in mid-line has no effect until the next line begins.
- R7: In the first cycle of line 160, the vertical-blank flag rises and the V-blank DMA trigger pulses. The V-blank interrupt pulses in that same cycle only if its enable is high.
- R8: The vertical-blank flag falls in the first cycle of line 227. It stays low from line 227 through line 159 of the next frame.
- R9: Every interrupt, DMA and draw output is high for one cycle at a time.
- R10: A compare value above 227 never sets the match flag and never raises the match interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_cmp | input | CMP_W (8) | Line number the counter is compared with |
| hblank_ie | input | 1 | Enable for the H-blank interrupt |
| vblank_ie | input | 1 | Enable for the V-blank interrupt |
| match_ie | input | 1 | Enable for the line-match interrupt |
| line | output | $clog2(LINES) (8) | Current line number |
| hblank | output | 1 | Horizontal-blank status level |
| vblank | output | 1 | Vertical-blank status level |
| match | output | 1 | Line-match status level |
| hblank_irq | output | 1 | H-blank interrupt pulse |
| vblank_irq | output | 1 | V-blank interrupt pulse |
| match_irq | output | 1 | Line-match interrupt pulse |
| hblank_dma | output | 1 | H-blank DMA trigger pulse |
| vblank_dma | output | 1 | V-blank DMA trigger pulse |
| draw | output | 1 | Visible line ready to draw |

## Verification
A cycle counter that is off by one moves the horizontal-blank edge and every pulse tied to it. The bench compares every output on every cycle, so such an error shows at the first blank of line 0. An error in the line counter or the vertical-blank set or clear shows at the first line change or at line 160 or 227, all within one frame. The compare path is tested with values at the visible edge, at the last line, above 227, and with the compare input changed in mid-line.

// File: rtl/lcd_tmg_pkg.sv
package lcd_tmg_pkg;
  localparam int DEF_ACTIVE_CYC = 960;
  localparam int DEF_BLANK_CYC  = 272;
  localparam int DEF_LINES      = 228;
  localparam int DEF_VISIBLE    = 160;
  localparam int DEF_CMP_W      = 8;

  typedef struct packed {
    logic act_end;   // last cycle of the active period
    logic line_end;  // last cycle of the line
  } dot_evt_t;
endpackage

// File: rtl/lcd_dot_counter.sv
module lcd_dot_counter
  import lcd_tmg_pkg::*;
#(
  parameter int ACTIVE_CYC = DEF_ACTIVE_CYC,
  parameter int BLANK_CYC  = DEF_BLANK_CYC
) (
  input  logic     clk,
  input  logic     rst_n,
  output dot_evt_t evt
);
  localparam int LINE_CYC = ACTIVE_CYC + BLANK_CYC;
  localparam int DW = $clog2(LINE_CYC);
  localparam logic [DW-1:0] ACT_LAST  = DW'(ACTIVE_CYC - 1);
  localparam logic [DW-1:0] LINE_LAST = DW'(LINE_CYC - 1);

  logic [DW-1:0] dot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 dot_q <= '0;
    else if (dot_q == LINE_LAST) dot_q <= '0;
    else                        dot_q <= dot_q + 1'b1;
  end

  assign evt.act_end  = (dot_q == ACT_LAST);
  assign evt.line_end = (dot_q == LINE_LAST);

  a_r3_dot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    dot_q <= LINE_LAST);
  a_r3_line_end_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    evt.line_end |=> dot_q == '0);
endmodule

// File: rtl/lcd_line_counter.sv
module lcd_line_counter
  import lcd_tmg_pkg::*;
#(
  parameter int LINES = DEF_LINES,
  parameter int LW    = $clog2(LINES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dot_evt_t      evt,
  output logic [LW-1:0] line_q,
  output logic [LW-1:0] line_nxt
);
  localparam logic [LW-1:0] LAST = LW'(LINES - 1);

  assign line_nxt = (line_q == LAST) ? '0 : line_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            line_q <= '0;
    else if (evt.line_end) line_q <= line_nxt;
  end

  a_r2_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (evt.line_end && line_q == LAST) |=> line_q == '0);
  a_r2_hold_mid_line: assert property (@(posedge clk) disable iff (!rst_n)
    !evt.line_end |=> $stable(line_q));
endmodule

// File: rtl/lcd_status_gen.sv
module lcd_status_gen
  import lcd_tmg_pkg::*;
#(
  parameter int LINES   = DEF_LINES,
  parameter int VISIBLE = DEF_VISIBLE,
  parameter int CMP_W   = DEF_CMP_W,
  parameter int LW      = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  dot_evt_t         evt,
  input  logic [LW-1:0]    line_q,
  input  logic [LW-1:0]    line_nxt,
  input  logic [CMP_W-1:0] line_cmp,
  input  logic             hblank_ie,
  input  logic             vblank_ie,
  input  logic             match_ie,
  output logic             hblank,
  output logic             vblank,
  output logic             match,
  output logic             hblank_irq,
  output logic             vblank_irq,
  output logic             match_irq,
  output logic             hblank_dma,
  output logic             vblank_dma,
  output logic             draw
);
  localparam int XW = (CMP_W > LW) ? CMP_W : LW;
  localparam logic [LW-1:0] VB_START = LW'(VISIBLE);
  localparam logic [LW-1:0] VB_CLEAR = LW'(LINES - 1);

  logic [XW-1:0] nxt_x, cmp_x;
  logic          hit;

  assign nxt_x = XW'(line_nxt);
  assign cmp_x = XW'(line_cmp);
  assign hit   = (nxt_x == cmp_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hblank     <= 1'b0;
      vblank     <= 1'b0;
      match      <= 1'b0;
      hblank_irq <= 1'b0;
      vblank_irq <= 1'b0;
      match_irq  <= 1'b0;
      hblank_dma <= 1'b0;
      vblank_dma <= 1'b0;
      draw       <= 1'b0;
    end else begin
      hblank_irq <= 1'b0;
      vblank_irq <= 1'b0;
      match_irq  <= 1'b0;
      hblank_dma <= 1'b0;
      vblank_dma <= 1'b0;
      draw       <= 1'b0;
      if (evt.act_end) begin
        hblank     <= 1'b1;
        hblank_dma <= 1'b1;
        hblank_irq <= hblank_ie;
        draw       <= (line_q < VB_START);
      end
      if (evt.line_end) begin
        hblank    <= 1'b0;
        match     <= hit;
        match_irq <= hit && match_ie;
        if (line_nxt == VB_START) begin
          vblank     <= 1'b1;
          vblank_dma <= 1'b1;
          vblank_irq <= vblank_ie;
        end
        if (line_nxt == VB_CLEAR) vblank <= 1'b0;
      end
    end
  end

  a_r4_hblank_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt.act_end |=> hblank && hblank_dma);
  a_r3_hblank_clears: assert property (@(posedge clk) disable iff (!rst_n)
    evt.line_end |=> !hblank);
  a_r5_draw_visible: assert property (@(posedge clk) disable iff (!rst_n)
    draw |-> hblank && (line_q < VB_START));
  a_r6_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_irq |-> match);
  a_r7_vblank_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(vblank) |-> (line_q == VB_START) && vblank_dma);
  a_r8_vblank_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(vblank) |-> line_q == VB_CLEAR);
  a_r9_hdma_single: assert property (@(posedge clk) disable iff (!rst_n)
    hblank_dma |=> !hblank_dma);
  a_r9_vdma_single: assert property (@(posedge clk) disable iff (!rst_n)
    vblank_dma |=> !vblank_dma);
endmodule

// File: rtl/lcd_line_timer.sv
module lcd_line_timer
  import lcd_tmg_pkg::*;
#(
  parameter int ACTIVE_CYC = DEF_ACTIVE_CYC,
  parameter int BLANK_CYC  = DEF_BLANK_CYC,
  parameter int LINES      = DEF_LINES,
  parameter int VISIBLE    = DEF_VISIBLE,
  parameter int CMP_W      = DEF_CMP_W,
  localparam int LW        = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CMP_W-1:0] line_cmp,
  input  logic             hblank_ie,
  input  logic             vblank_ie,
  input  logic             match_ie,
  output logic [LW-1:0]    line,
  output logic             hblank,
  output logic             vblank,
  output logic             match,
  output logic             hblank_irq,
  output logic             vblank_irq,
  output logic             match_irq,
  output logic             hblank_dma,
  output logic             vblank_dma,
  output logic             draw
);
  dot_evt_t      evt;
  logic [LW-1:0] line_nxt;

  lcd_dot_counter #(.ACTIVE_CYC(ACTIVE_CYC), .BLANK_CYC(BLANK_CYC)) u_dot (
    .clk(clk), .rst_n(rst_n), .evt(evt)
  );

  lcd_line_counter #(.LINES(LINES), .LW(LW)) u_line (
    .clk(clk), .rst_n(rst_n), .evt(evt), .line_q(line), .line_nxt(line_nxt)
  );

  lcd_status_gen #(.LINES(LINES), .VISIBLE(VISIBLE), .CMP_W(CMP_W), .LW(LW)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt), .line_q(line), .line_nxt(line_nxt),
    .line_cmp(line_cmp), .hblank_ie(hblank_ie), .vblank_ie(vblank_ie),
    .match_ie(match_ie), .hblank(hblank), .vblank(vblank), .match(match),
    .hblank_irq(hblank_irq), .vblank_irq(vblank_irq), .match_irq(match_irq),
    .hblank_dma(hblank_dma), .vblank_dma(vblank_dma), .draw(draw)
  );
endmodule

// File: tb/lcd_line_timer_tb.sv
module lcd_line_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ACT = 12;
  localparam int BLK = 4;
  localparam int LC  = ACT + BLK;
  localparam int NL  = 228;
  localparam int VIS = 160;
  localparam int RUN = NL * LC + 3 * LC;

  // vector: {compare value, hblank_ie, vblank_ie, match_ie}
  localparam logic [10:0] VEC [6] = '{
    {8'd5,   3'b111}, {8'd0,   3'b000}, {8'd160, 3'b001},
    {8'd227, 3'b110}, {8'd228, 3'b111}, {8'd255, 3'b101}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] line_cmp = '0;
  logic       hblank_ie = 1'b0, vblank_ie = 1'b0, match_ie = 1'b0;
  logic [7:0] line;
  logic       hblank, vblank, match, hblank_irq, vblank_irq, match_irq;
  logic       hblank_dma, vblank_dma, draw;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_line_timer #(.ACTIVE_CYC(ACT), .BLANK_CYC(BLK), .LINES(NL), .VISIBLE(VIS)) u_dut (
    .clk(clk), .rst_n(rst_n), .line_cmp(line_cmp), .hblank_ie(hblank_ie),
    .vblank_ie(vblank_ie), .match_ie(match_ie), .line(line), .hblank(hblank),
    .vblank(vblank), .match(match), .hblank_irq(hblank_irq), .vblank_irq(vblank_irq),
    .match_irq(match_irq), .hblank_dma(hblank_dma), .vblank_dma(vblank_dma), .draw(draw)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      if (n_fail < 30)
        $display("FAIL %s %s: got %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // compare every output with the value the requirements give after n edges
  task automatic check_at(int n);
    int dot = n % LC;
    int ln  = (n / LC) % NL;
    bit hbp = (dot == ACT);
    bit adv = (dot == 0) && (n > 0);
    bit hit = (n >= LC) && (ln == int'(line_cmp));
    string mreq = (line_cmp > 8'd227) ? "R10" : "R6";
    chk(n == 0 ? "R1" : "R2", "line", int'(line), ln);
    chk("R3", "hblank", int'(hblank), int'(dot >= ACT));
    chk("R4", "hblank_dma", int'(hblank_dma), int'(hbp));          // R9 width
    chk("R4", "hblank_irq", int'(hblank_irq), int'(hbp && hblank_ie));
    chk("R5", "draw", int'(draw), int'(hbp && ln < VIS));
    chk(mreq, "match", int'(match), int'(hit));
    chk(mreq, "match_irq", int'(match_irq), int'(hit && adv && match_ie));
    chk("R8", "vblank", int'(vblank), int'(ln >= VIS && ln < NL - 1));
    chk("R7", "vblank_dma", int'(vblank_dma), int'(adv && ln == VIS)); // R9 width
    chk("R7", "vblank_irq", int'(vblank_irq), int'(adv && ln == VIS && vblank_ie));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic step(ref int n);
    @(negedge clk); n++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int n;
    for (int v = 0; v < 6; v++) begin
      line_cmp  = VEC[v][10:3];
      hblank_ie = VEC[v][2];
      vblank_ie = VEC[v][1];
      match_ie  = VEC[v][0];
      do_reset();
      n = 0;
      check_at(0);  // R1 reset state
      for (int c = 0; c < RUN; c++) begin
        step(n);
        check_at(n);
      end
    end

    // R1: reset in mid-frame returns every output to idle
    line_cmp = 8'd2; hblank_ie = 1'b1; vblank_ie = 1'b1; match_ie = 1'b1;
    do_reset();
    n = 0;
    for (int c = 0; c < 12 * LC + ACT; c++) step(n);
    rst_n = 1'b0;
    #1;
    chk("R1", "line after reset", int'(line), 0);
    chk("R1", "hblank after reset", int'(hblank), 0);
    chk("R1", "match after reset", int'(match), 0);
    chk("R1", "pulses after reset",
        int'({hblank_irq, vblank_irq, match_irq, hblank_dma, vblank_dma, draw}), 0);
    @(negedge clk); rst_n = 1'b1;
    n = 0;
    check_at(0);
    for (int c = 0; c < ACT; c++) begin step(n); check_at(n); end  // R1 first blank at ACT

    // R6: a mid-line change of the compare value waits for the next line
    line_cmp = 8'd5; match_ie = 1'b1;
    do_reset();
    n = 0;
    while (n < LC + 4) step(n);
    line_cmp = 8'd1;                     // current line is 1
    step(n);
    chk("R6", "match mid-line cmp change", int'(match), 0);
    chk("R6", "match_irq mid-line cmp change", int'(match_irq), 0);
    while (n < 2 * LC) step(n);
    chk("R6", "match on line 2 with cmp 1", int'(match), 0);
    line_cmp = 8'd3;
    while (n < 3 * LC) step(n);
    chk("R6", "match on reaching cmp line", int'(match), 1);
    chk("R6", "match_irq on reaching cmp line", int'(match_irq), 1);
    step(n);
    chk("R9", "match_irq one cycle", int'(match_irq), 0);
    chk("R6", "match level holds", int'(match), 1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule